// File: doc/BRIEF.md
# Parallel NOR Whole-Array Erase Command Decoder

This block sits on the device side of a word-wide parallel NOR-style memory model. It watches host write cycles on the address and data bus. A whole-array erase starts only after six writes in a row, each with an exact address and data value. Any write that breaks the pattern sends the matcher back to its first step and leaves the array untouched.

Once the sixth write is accepted, an embedded engine runs through the internal array twice. The first pass programs every word to zero and reads each one back to verify it. The second pass sets every word to all ones. Each word spends a parameterised number of wait cycles in each pass.

While the engine runs, host writes are ignored and the erase cannot be suspended. Host reads return a status word instead of array data. A synchronous hardware reset stops the engine at once and leaves whatever the two passes had already written. After the engine finishes, reads return array contents again.

Top module: `nor_erase_ctrl`

## Requirements
- R1: After reset, `busy` is low, the matcher is at its first step, and a read of word i returns the power-up pattern ((i * 0x1357) XOR 0xA5C3), truncated to 16 bits.
- R2: With `byte_mode` low, the erase starts after six consecutive writes whose (address, data) pairs are (0x555, 0x00AA), (0x2AA, 0x0055), (0x555, 0x0080), (0x555, 0x00AA), (0x2AA, 0x0055), (0x555, 0x0010). The full 16-bit data must match.
- R3: With `byte_mode` high, the addresses 0x555 and 0x2AA in that pattern become 0xAAA and 0x555. Only `wdata[7:0]` is compared, and `wdata[15:8]` may hold anything.
- R4: A write whose address or data differs from the value expected at the current step returns the matcher to its first step. It starts nothing and changes no array word.
- R5: `busy` rises at the clock edge that samples the sixth matching write. It stays high for exactly DEPTH*(2*CYC_PER_LOC+4) cycles.
- R6: The first pass writes and verifies zero in every word, in ascending order. The second pass then writes 0xFFFF to every word in ascending order, so after completion every word reads 0xFFFF.
- R7: Writes while `busy` is high are ignored. This includes a complete six-write pattern. A pattern begun during the erase is not continued after it ends.
- R8: A read while `busy` is high returns a status word one cycle later. Bit 7 is 0, every bit other than bit 6 is 0, and bit 6 is 0 on the first read of an erase and inverts on each further read.
- R9: Asserting `rst` ends an erase at the next edge: `busy` drops and the matcher returns to its first step. Words already rewritten keep their new value; in the second pass, words below the current one read 0xFFFF and the rest read 0x0000.
- R10: A read with `rd_en` high while `busy` is low returns, one cycle later, the array word at `addr` (bits IDX_W-1:0 in word mode, bits IDX_W:1 in byte mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset; aborts an erase |
| byte_mode | input | 1 | 1 selects byte addressing for the unlock pattern and reads |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| rd_en | input | 1 | Host read strobe; data valid on `rdata` the next cycle |
| addr | input | ADDR_W | Host address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Array word or status word |
| busy | output | 1 | High while the embedded erase runs |

## Verification
The exact pattern is sent in word and byte addressing, with junk in the upper byte for the byte case, to show that each mode decodes its own unlock addresses and data width. Patterns with one address or data bit corrupted at a random step are checked against a reference matcher after every write. This separates a correct reset-to-first-step from a matcher that skips, holds or restarts wrongly. A reset at a chosen cycle in the second pass tells the ascending pass order and per-word timing apart from other orderings, because the expected boundary between 0xFFFF and 0x0000 words is fixed. Writes and reads issued during an erase show that commands are ignored and that the status toggle bit alternates.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_PWAIT,
    ENG_PWR,
    ENG_PVRD,
    ENG_PVCK,
    ENG_EWAIT,
    ENG_EWR
  } eng_state_e;

  localparam int unsigned SEQ_LEN  = 6;
  localparam int unsigned STEP_W   = 3;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned SEQ_AW   = 12;

  // Unlock address expected at a given step of the erase pattern.
  function automatic logic [SEQ_AW-1:0] seq_addr(input logic [STEP_W-1:0] step,
                                                 input logic byte_mode);
    logic [SEQ_AW-1:0] far_a, near_a;
    far_a  = byte_mode ? 12'hAAA : 12'h555;
    near_a = byte_mode ? 12'h555 : 12'h2AA;
    if (step == 3'd1 || step == 3'd4) return near_a;
    return far_a;
  endfunction

  // Low data byte expected at a given step of the erase pattern.
  function automatic logic [7:0] seq_data(input logic [STEP_W-1:0] step);
    case (step)
      3'd0, 3'd3: return 8'hAA;
      3'd1, 3'd4: return 8'h55;
      3'd2:       return 8'h80;
      default:    return 8'h10;
    endcase
  endfunction

endpackage

// File: rtl/cmd_matcher.sv
module cmd_matcher
  import nor_erase_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                hold,
  input  logic                byte_mode,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [STEP_W-1:0]   step_o,
  output logic                start_o
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

  logic [STEP_W-1:0] step_q;
  logic              addr_hit, data_hit, hit;

  always_comb begin
    addr_hit = (addr == ADDR_W'(seq_addr(step_q, byte_mode)));
    if (byte_mode) data_hit = (wdata[7:0] == seq_data(step_q));
    else           data_hit = (wdata == {8'h00, seq_data(step_q)});
    hit = addr_hit && data_hit;
  end

  assign start_o = wr_en && !hold && hit && (step_q == LAST_STEP);
  assign step_o  = step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
    end else if (hold) begin
      step_q <= '0;
    end else if (wr_en) begin
      if (hit && step_q != LAST_STEP) step_q <= step_q + 1'b1;
      else                            step_q <= '0;
    end
  end

endmodule

// File: rtl/erase_engine.sv
module erase_engine
  import nor_erase_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned CYC_PER_LOC = 4,
  parameter int unsigned IDX_W       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] ram_rdata,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_addr,
  output logic [WORD_W-1:0] ram_wdata,
  output logic              busy
);

  localparam int unsigned CNT_W = (CYC_PER_LOC > 1) ? $clog2(CYC_PER_LOC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC_PER_LOC - 1);
  localparam logic [IDX_W-1:0] LOC_LAST = IDX_W'(DEPTH - 1);

  eng_state_e       state_q, state_n;
  logic [IDX_W-1:0] loc_q, loc_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_q;

  always_comb begin
    state_n = state_q;
    loc_n   = loc_q;
    cnt_n   = cnt_q;
    case (state_q)
      ENG_IDLE: if (start) begin
        state_n = ENG_PWAIT;
        loc_n   = '0;
        cnt_n   = '0;
      end
      ENG_PWAIT: begin
        if (cnt_q == CNT_LAST) begin
          state_n = ENG_PWR;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ENG_PWR:  state_n = ENG_PVRD;
      ENG_PVRD: state_n = ENG_PVCK;
      ENG_PVCK: begin
        if (ram_rdata != '0) begin
          state_n = ENG_PWR;
        end else if (loc_q == LOC_LAST) begin
          state_n = ENG_EWAIT;
          loc_n   = '0;
        end else begin
          state_n = ENG_PWAIT;
          loc_n   = loc_q + 1'b1;
        end
      end
      ENG_EWAIT: begin
        if (cnt_q == CNT_LAST) begin
          state_n = ENG_EWR;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ENG_EWR: begin
        if (loc_q == LOC_LAST) begin
          state_n = ENG_IDLE;
          loc_n   = '0;
        end else begin
          state_n = ENG_EWAIT;
          loc_n   = loc_q + 1'b1;
        end
      end
      default: state_n = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      loc_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      loc_q   <= loc_n;
      cnt_q   <= cnt_n;
      busy_q  <= (state_n != ENG_IDLE);
    end
  end

  assign ram_we    = (state_q == ENG_PWR) || (state_q == ENG_EWR);
  assign ram_wdata = (state_q == ENG_PWR) ? '0 : '1;
  assign ram_addr  = loc_q;
  assign busy      = busy_q;

endmodule

// File: rtl/flash_array.sv
module flash_array
  import nor_erase_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  // Power-up contents: a computed non-blank pattern.
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = WORD_W'((32'(i) * 32'h1357) ^ 32'hA5C3);
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/nor_erase_ctrl.sv
module nor_erase_ctrl
  import nor_erase_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned CYC_PER_LOC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              busy
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [STEP_W-1:0] match_step;
  logic              start;
  logic              ram_we;
  logic [IDX_W-1:0]  eng_addr;
  logic [WORD_W-1:0] ram_wdata;
  logic [WORD_W-1:0] ram_dout;
  logic [IDX_W-1:0]  host_idx;
  logic [IDX_W-1:0]  ram_raddr;
  logic              toggle_q;
  logic              stat_sel_q;
  logic [WORD_W-1:0] stat_q;

  cmd_matcher #(.ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst(rst), .wr_en(wr_en), .hold(busy), .byte_mode(byte_mode),
    .addr(addr), .wdata(wdata), .step_o(match_step), .start_o(start)
  );

  erase_engine #(.DEPTH(DEPTH), .CYC_PER_LOC(CYC_PER_LOC), .IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst(rst), .start(start), .ram_rdata(ram_dout),
    .ram_we(ram_we), .ram_addr(eng_addr), .ram_wdata(ram_wdata), .busy(busy)
  );

  assign host_idx  = byte_mode ? addr[IDX_W:1] : addr[IDX_W-1:0];
  assign ram_raddr = busy ? eng_addr : host_idx;

  flash_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
    .clk(clk), .we(ram_we), .waddr(eng_addr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_dout)
  );

  // Status path: bit 6 alternates on each read during an erase.
  always_ff @(posedge clk) begin
    if (rst) begin
      toggle_q   <= 1'b0;
      stat_sel_q <= 1'b0;
      stat_q     <= '0;
    end else begin
      if (!busy) toggle_q <= 1'b0;
      if (rd_en) begin
        stat_sel_q <= busy;
        if (busy) begin
          stat_q   <= {8'h00, 1'b0, toggle_q, 6'h00};
          toggle_q <= ~toggle_q;
        end
      end
    end
  end

  assign rdata = stat_sel_q ? stat_q : ram_dout;

endmodule

// File: rtl/nor_erase_ctrl_chk.sv
module nor_erase_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        rd_en,
  input logic        busy,
  input logic [15:0] rdata,
  input logic        ram_we,
  input logic [15:0] ram_wdata,
  input logic [2:0]  match_step
);

  assert_start_on_write_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en));

  assert_step_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (match_step != $past(match_step)) |->
      (match_step == $past(match_step) + 3'd1 || match_step == 3'd0));

  assert_step_range_R2: assert property (@(posedge clk) disable iff (rst)
    match_step <= 3'd5);

  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> (match_step == 3'd0));

  assert_array_write_R6: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (busy && (ram_wdata == 16'h0000 || ram_wdata == 16'hFFFF)));

  assert_status_word_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy) |=> ((rdata & 16'hFFBF) == 16'h0000));

  assert_reset_abort_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !busy);

endmodule

bind nor_erase_ctrl nor_erase_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .busy(busy),
  .rdata(rdata), .ram_we(ram_we), .ram_wdata(ram_wdata), .match_step(match_step)
);

// File: tb/nor_erase_ctrl_tb.sv
`timescale 1ns/1ps
module nor_erase_ctrl_tb;

  localparam int ADDR_W = 12;
  localparam int DEPTH  = 16;
  localparam int CYC    = 4;
  localparam int BUSY_LEN = DEPTH * (2 * CYC + 4);
  localparam int PRE_LEN  = DEPTH * (CYC + 3);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              byte_mode = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       wdata = '0;
  logic [15:0]       rdata;
  logic              busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int model_step = 0;

  always #2.5 clk = ~clk;

  nor_erase_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CYC_PER_LOC(CYC)) u_dut (
    .clk(clk), .rst(rst), .byte_mode(byte_mode), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  function automatic logic [15:0] init_word(input int i);
    return 16'((32'(i) * 32'h1357) ^ 32'hA5C3);
  endfunction

  function automatic logic [11:0] pat_addr(input int s, input bit bm);
    if (s == 1 || s == 4) return bm ? 12'h555 : 12'h2AA;
    return bm ? 12'hAAA : 12'h555;
  endfunction

  function automatic logic [7:0] pat_data(input int s);
    case (s)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2:    return 8'h80;
      default: return 8'h10;
    endcase
  endfunction

  // Reference matcher; returns 1 when this write should start an erase.
  function automatic bit model_write(input logic [11:0] a, input logic [15:0] d,
                                     input bit bm);
    bit hit;
    hit = (a == pat_addr(model_step, bm)) &&
          (bm ? (d[7:0] == pat_data(model_step)) : (d == {8'h00, pat_data(model_step)}));
    if (hit && model_step == 5) begin model_step = 0; return 1'b1; end
    if (hit) model_step++;
    else     model_step = 0;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic send_steps(input int first, input int last, input bit bm);
    for (int s = first; s <= last; s++) begin
      bus_write(pat_addr(s, bm), bm ? {8'($urandom), pat_data(s)} : {8'h00, pat_data(s)});
    end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_step = 0;
  endtask

  initial begin
    logic [15:0] rd;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state and power-up contents
    chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(12'(i), rd);
      chk(rd == init_word(i), "R1 power-up word", rd, init_word(i));
    end

    // R4: wrong sixth data, then wrong second address
    send_steps(0, 4, 1'b0);
    bus_write(12'h555, 16'h0030);
    chk(busy == 1'b0, "R4 wrong final data", 32'(busy), 0);
    bus_write(12'h555, 16'h00AA);
    bus_write(12'h2AB, 16'h0055);
    send_steps(2, 5, 1'b0);
    chk(busy == 1'b0, "R4 wrong second address", 32'(busy), 0);
    bus_read(12'd5, rd);
    chk(rd == init_word(5), "R4 array unchanged", rd, init_word(5));

    // R2 + R9: start in word mode, reset in the middle of the second pass
    send_steps(0, 5, 1'b0);
    chk(busy == 1'b1, "R2 word pattern starts erase", 32'(busy), 1);
    repeat (PRE_LEN + 3 * (CYC + 1) + 1) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R9 busy drops on reset", 32'(busy), 0);
    rst = 1'b0;
    model_step = 0;
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(12'(i), rd);
      chk(rd == ((i < 3) ? 16'hFFFF : 16'h0000), "R9 partial contents", rd,
          (i < 3) ? 16'hFFFF : 16'h0000);
    end

    // R5 + R6 + R10: full erase
    send_steps(0, 5, 1'b0);
    chk(busy == 1'b1, "R2 restart after reset", 32'(busy), 1);
    wait_idle(n);
    chk(n == BUSY_LEN, "R5 busy length", n, BUSY_LEN);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(12'(i), rd);
      chk(rd == 16'hFFFF, "R6 R10 erased word", rd, 16'hFFFF);
    end

    // R8 + R7: status reads and ignored commands
    send_steps(0, 5, 1'b0);
    bus_read(12'd0, rd);
    chk(rd == 16'h0000, "R8 first status read", rd, 16'h0000);
    bus_read(12'd0, rd);
    chk(rd == 16'h0040, "R8 second status read", rd, 16'h0040);
    bus_read(12'd0, rd);
    chk(rd == 16'h0000, "R8 third status read", rd, 16'h0000);
    for (int s = 0; s < 6; s++) begin
      bus_write(pat_addr(s, 1'b0), {8'h00, pat_data(s)});
      chk(busy == 1'b1, "R7 busy during ignored write", 32'(busy), 1);
    end
    wait_idle(n);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R7 pattern during erase ignored", 32'(busy), 0);
    send_steps(0, 5, 1'b0);
    send_steps(0, 2, 1'b0);
    wait_idle(n);
    model_step = 0;
    send_steps(3, 5, 1'b0);
    chk(busy == 1'b0, "R7 split pattern not continued", 32'(busy), 0);
    bus_read(12'd7, rd);
    chk(rd == 16'hFFFF, "R10 array read after erase", rd, 16'hFFFF);

    // R3: byte mode
    byte_mode = 1'b1;
    bus_write(12'h555, 16'h00AA);
    send_steps(1, 5, 1'b1);
    chk(busy == 1'b0, "R3 word address rejected in byte mode", 32'(busy), 0);
    send_steps(0, 5, 1'b1);
    chk(busy == 1'b1, "R3 byte pattern starts erase", 32'(busy), 1);
    wait_idle(n);
    chk(n == BUSY_LEN, "R3 R5 byte mode busy length", n, BUSY_LEN);
    bus_read(12'd6, rd);
    chk(rd == 16'hFFFF, "R3 R10 byte mode read", rd, 16'hFFFF);
    byte_mode = 1'b0;

    // R4 R2 R3: random single-bit corruption against the reference matcher
    do_reset();
    for (int t = 0; t < 60; t++) begin
      bit bm;
      bm = 1'($urandom % 2);
      byte_mode = bm;
      for (int s = 0; s < 6; s++) begin
        logic [11:0] a;
        logic [15:0] d;
        bit exp_start;
        int r;
        a = pat_addr(s, bm);
        d = bm ? {8'($urandom), pat_data(s)} : {8'h00, pat_data(s)};
        r = int'($urandom % 10);
        if (r == 0) a = a ^ 12'(1 << ($urandom % 12));
        if (r == 1) d = d ^ 16'(1 << ($urandom % (bm ? 8 : 16)));
        exp_start = model_write(a, d, bm);
        bus_write(a, d);
        chk(busy == exp_start, "R4 random pattern start", 32'(busy), 32'(exp_start));
        if (busy) begin
          wait_idle(n);
          chk(n == BUSY_LEN, "R5 random busy length", n, BUSY_LEN);
          model_step = 0;
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule